// File: doc/BRIEF.md
# Late-Write Strobe Sequencer for a Latched-Address Static RAM

This block is a synchronous master for an asynchronous static RAM. The RAM latches its address when the chip-enable strobe falls and latches its single data bit when the write-enable strobe falls. The block accepts one write at a time through a small request port: a valid strobe, an address, one data bit, a ready output and a one-cycle completion pulse. It then generates a late write. Chip-enable goes low first. Write-enable goes low afterwards, inside the active enable, and both strobes return high on the same clock edge. A precharge interval with enable high then follows before the next cycle can begin.

Every timing minimum is a parameter counted in system-clock cycles. The block derives a single cycle schedule from these parameters at elaboration, so no pin timing depends on run-time state. The memory output is never sampled: during a late write it may drive valid or undefined data, and the block has no input for it. With `DROP_IDLE` set, the address and data pins are driven to zero once their hold windows close and whenever the memory is idle. This makes the hold windows visible on the pins. With `DROP_IDLE` clear, the pins simply keep the last request.

Top module: `sram_late_write_ctl`

## Requirements
- R1: Synchronous reset (`rst` high) holds `ram_en_n` and `ram_we_n` high and places the block in precharge. After reset is released, `wr_ready` stays low for exactly `T_PC` clock edges and then goes high. No `wr_done` pulse follows reset.
- R2: A request is accepted on a clock edge where `wr_req` and `wr_ready` are both high. The request address appears on `ram_addr` at that edge and `ram_en_n` falls exactly `T_AS` edges later. With `DROP_IDLE`=1 the address stays on the pins for exactly `T_AH` edges after the enable fall and is driven to zero after that.
- R3: `ram_we_n` falls exactly W = max(`T_EW`, `T_DS`-`T_AS`) edges after `ram_en_n` falls. It is never low while `ram_en_n` is high, and it only falls while `ram_en_n` was already low on the previous edge.
- R4: The data bit appears on `ram_din` at the acceptance edge, together with the address. At the `ram_we_n` fall it equals the accepted `wr_bit`. With `DROP_IDLE`=1 it stays for exactly `T_DH` edges after that fall and is then driven to zero.
- R5: `ram_en_n` stays low for exactly L = max(`T_EL`, `T_AH`, W+`T_DH`, W+max(`T_WP`,`T_WE`)) edges. `ram_we_n` rises on the same edge as `ram_en_n`, so write-enable is low for L-W edges, which is at least `T_WP` and at least `T_WE`.
- R6: After `ram_en_n` rises, it stays high for at least `T_PC` edges. `wr_done` goes high for exactly one cycle `T_PC` edges after the rise, and `wr_ready` is high in that same cycle.
- R7: `wr_ready` is high only while the block is idle, and both strobes are high then. A `wr_req` presented while `wr_ready` is low starts no memory cycle and does not alter the cycle in progress.
- R8: If `wr_req` is held high, the next request is accepted on the edge that ends the `wr_done` cycle. The enable-high gap between the two memory cycles is then exactly `T_PC`+1+`T_AS` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Write request valid |
| wr_addr | input | AW | Write address |
| wr_bit | input | 1 | Write data bit |
| wr_ready | output | 1 | Block idle, request will be accepted |
| wr_done | output | 1 | One-cycle pulse when precharge after a write ends |
| ram_en_n | output | 1 | Memory chip-enable, active low |
| ram_we_n | output | 1 | Memory write-enable, active low |
| ram_addr | output | AW | Memory address pins |
| ram_din | output | 1 | Memory data-in pin |

## Verification
The hardest situation to reach from the ports is the handover between two consecutive writes. That is the cycle where `wr_done` and `wr_ready` are both high and a held request must be taken immediately, while the previous precharge must still have lasted its full length. The bench keeps `wr_req` asserted across a whole write and swaps the address once the first request is taken. It then times the enable-high gap between the two memory cycles. A second scenario raises a request during an active write and confirms that no extra enable fall occurs and that the latched address does not change.

// File: rtl/sram_lw_pkg.sv
package sram_lw_pkg;

   typedef enum logic [1:0] {
      LW_IDLE   = 2'd0,
      LW_SETUP  = 2'd1,
      LW_ACTIVE = 2'd2,
      LW_PRECH  = 2'd3
   } lw_phase_e;

   function automatic int lw_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_lw_timer.sv
module sram_lw_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          restart,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] cnt_nxt
);
   localparam logic [CW-1:0] CNT_TOP = '1;

   // saturating phase counter, cleared on every phase change
   always_comb begin
      if (restart)
         cnt_nxt = '0;
      else if (cnt == CNT_TOP)
         cnt_nxt = cnt;
      else
         cnt_nxt = cnt + CW'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt_nxt;
   end
endmodule

// File: rtl/sram_lw_seq.sv
module sram_lw_seq
   import sram_lw_pkg::*;
#(
   parameter int T_AS  = 2,
   parameter int T_AH  = 1,
   parameter int T_DH  = 2,
   parameter int T_PC  = 3,
   parameter int W_DLY = 2,
   parameter int L_CYC = 5,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] cnt_nxt,
   output logic          restart,
   output logic          accept,
   output logic          ready,
   output logic          done,
   output logic          en_n_nxt,
   output logic          we_n_nxt,
   output logic          ahold_nxt,
   output logic          dhold_nxt
);
   localparam logic [CW-1:0] AS_LAST = CW'(T_AS - 1);
   localparam logic [CW-1:0] EN_LAST = CW'(L_CYC - 1);
   localparam logic [CW-1:0] PC_LAST = CW'(T_PC - 1);
   localparam logic [CW-1:0] WE_AT   = CW'(W_DLY);
   localparam logic [CW-1:0] AH_END  = CW'(T_AH);
   localparam logic [CW-1:0] DH_END  = CW'(W_DLY + T_DH);

   lw_phase_e phase, phase_nxt;
   logic      finish;
   logic      owed;

   always_comb begin
      phase_nxt = phase;
      restart   = 1'b0;
      accept    = 1'b0;
      finish    = 1'b0;
      unique case (phase)
         LW_IDLE: if (req_valid) begin
            accept    = 1'b1;
            restart   = 1'b1;
            phase_nxt = LW_SETUP;
         end
         LW_SETUP: if (cnt == AS_LAST) begin
            restart   = 1'b1;
            phase_nxt = LW_ACTIVE;
         end
         LW_ACTIVE: if (cnt == EN_LAST) begin
            restart   = 1'b1;
            phase_nxt = LW_PRECH;
         end
         LW_PRECH: if (cnt == PC_LAST) begin
            restart   = 1'b1;
            finish    = 1'b1;
            phase_nxt = LW_IDLE;
         end
         default: phase_nxt = LW_PRECH;
      endcase
   end

   // pin plan for the coming cycle, decoded from next phase and count
   always_comb begin
      en_n_nxt  = (phase_nxt != LW_ACTIVE);
      we_n_nxt  = !((phase_nxt == LW_ACTIVE) && (cnt_nxt >= WE_AT));
      ahold_nxt = (phase_nxt == LW_SETUP) ||
                  ((phase_nxt == LW_ACTIVE) && (cnt_nxt < AH_END));
      dhold_nxt = (phase_nxt == LW_SETUP) ||
                  ((phase_nxt == LW_ACTIVE) && (cnt_nxt < DH_END));
   end

   assign ready = (phase == LW_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= LW_PRECH;
         owed  <= 1'b0;
         done  <= 1'b0;
      end else begin
         phase <= phase_nxt;
         done  <= finish && owed;
         if (accept)      owed <= 1'b1;
         else if (finish) owed <= 1'b0;
      end
   end
endmodule

// File: rtl/sram_lw_pins.sv
module sram_lw_pins #(
   parameter int AW        = 8,
   parameter bit DROP_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [AW-1:0] addr_in,
   input  logic          bit_in,
   input  logic          en_n_nxt,
   input  logic          we_n_nxt,
   input  logic          ahold_nxt,
   input  logic          dhold_nxt,
   output logic          ram_en_n,
   output logic          ram_we_n,
   output logic [AW-1:0] ram_addr,
   output logic          ram_din
);
   logic [AW-1:0] addr_q;
   logic          bit_q;
   logic [AW-1:0] addr_src;
   logic          bit_src;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         bit_q  <= 1'b0;
      end else if (load) begin
         addr_q <= addr_in;
         bit_q  <= bit_in;
      end
   end

   assign addr_src = load ? addr_in : addr_q;
   assign bit_src  = load ? bit_in  : bit_q;

   // strobes are registered so they leave the block glitch free
   always_ff @(posedge clk) begin
      if (rst) begin
         ram_en_n <= 1'b1;
         ram_we_n <= 1'b1;
      end else begin
         ram_en_n <= en_n_nxt;
         ram_we_n <= we_n_nxt;
      end
   end

   generate
      if (DROP_IDLE) begin : g_drop
         always_ff @(posedge clk) begin
            if (rst) begin
               ram_addr <= '0;
               ram_din  <= 1'b0;
            end else begin
               ram_addr <= ahold_nxt ? addr_src : '0;
               ram_din  <= dhold_nxt ? bit_src  : 1'b0;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (rst) begin
               ram_addr <= '0;
               ram_din  <= 1'b0;
            end else if (load) begin
               ram_addr <= addr_in;
               ram_din  <= bit_in;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sram_late_write_ctl.sv
module sram_late_write_ctl
   import sram_lw_pkg::*;
#(
   parameter int AW        = 8,
   parameter int T_AS      = 2,
   parameter int T_AH      = 1,
   parameter int T_EW      = 1,
   parameter int T_DS      = 4,
   parameter int T_DH      = 2,
   parameter int T_WP      = 3,
   parameter int T_WE      = 2,
   parameter int T_EL      = 4,
   parameter int T_PC      = 3,
   parameter bit DROP_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_req,
   input  logic [AW-1:0] wr_addr,
   input  logic          wr_bit,
   output logic          wr_ready,
   output logic          wr_done,
   output logic          ram_en_n,
   output logic          ram_we_n,
   output logic [AW-1:0] ram_addr,
   output logic          ram_din
);
   // R3: write-enable delay after enable fall, also covering data setup
   localparam int W_DLY = lw_max(T_EW, T_DS - T_AS);
   // R5: enable low width covering every window inside the active phase
   localparam int L_CYC = lw_max(lw_max(T_EL, T_AH),
                                 lw_max(W_DLY + T_DH, W_DLY + lw_max(T_WP, T_WE)));
   localparam int SPAN  = lw_max(lw_max(L_CYC, T_AS), T_PC);
   localparam int CW    = $clog2(SPAN + 1) + 1;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("sram_late_write_ctl: AW must be at least 1");
      end
      if (T_AS < 1 || T_AH < 1 || T_EW < 1 || T_DS < 1 || T_DH < 1 ||
          T_WP < 1 || T_WE < 1 || T_EL < 1 || T_PC < 1) begin : g_bad_t
         $error("sram_late_write_ctl: every interval must be at least one cycle");
      end
   endgenerate

   logic [CW-1:0] cnt, cnt_nxt;
   logic          restart, accept;
   logic          en_n_nxt, we_n_nxt, ahold_nxt, dhold_nxt;

   sram_lw_timer #(.CW(CW)) timer_i (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt)
   );

   sram_lw_seq #(
      .T_AS  (T_AS),
      .T_AH  (T_AH),
      .T_DH  (T_DH),
      .T_PC  (T_PC),
      .W_DLY (W_DLY),
      .L_CYC (L_CYC),
      .CW    (CW)
   ) seq_i (
      .clk       (clk),
      .rst       (rst),
      .req_valid (wr_req),
      .cnt       (cnt),
      .cnt_nxt   (cnt_nxt),
      .restart   (restart),
      .accept    (accept),
      .ready     (wr_ready),
      .done      (wr_done),
      .en_n_nxt  (en_n_nxt),
      .we_n_nxt  (we_n_nxt),
      .ahold_nxt (ahold_nxt),
      .dhold_nxt (dhold_nxt)
   );

   sram_lw_pins #(.AW(AW), .DROP_IDLE(DROP_IDLE)) pins_i (
      .clk       (clk),
      .rst       (rst),
      .load      (accept),
      .addr_in   (wr_addr),
      .bit_in    (wr_bit),
      .en_n_nxt  (en_n_nxt),
      .we_n_nxt  (we_n_nxt),
      .ahold_nxt (ahold_nxt),
      .dhold_nxt (dhold_nxt),
      .ram_en_n  (ram_en_n),
      .ram_we_n  (ram_we_n),
      .ram_addr  (ram_addr),
      .ram_din   (ram_din)
   );
endmodule

// File: rtl/sram_lw_chk.sv
module sram_lw_chk #(
   parameter int T_EL = 4,
   parameter int T_PC = 3,
   parameter int T_WP = 3,
   parameter int T_WE = 2
) (
   input logic clk,
   input logic rst,
   input logic ram_en_n,
   input logic ram_we_n,
   input logic wr_ready,
   input logic wr_done
);
   logic [15:0] lo_run, hi_run, we_run;

   // run-length counters of the strobes, saturating
   always_ff @(posedge clk) begin
      if (rst) begin
         lo_run <= '0;
         hi_run <= '0;
         we_run <= '0;
      end else begin
         lo_run <= ram_en_n ? 16'd0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1);
         hi_run <= !ram_en_n ? 16'd0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1);
         we_run <= ram_we_n ? 16'd0 : ((we_run == 16'hFFFF) ? we_run : we_run + 16'd1);
      end
   end

   // R3
   strobe_order_chk: assert property (@(posedge clk) disable iff (rst)
      !ram_we_n |-> !ram_en_n);

   // R3
   late_we_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(ram_we_n) |-> $past(!ram_en_n));

   // R5
   joint_release_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ram_en_n) |-> $rose(ram_we_n));

   // R5
   en_width_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ram_en_n) |-> (lo_run >= 16'(T_EL)));

   // R5
   we_width_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ram_we_n) |-> ((we_run >= 16'(T_WP)) && (we_run >= 16'(T_WE))));

   // R6
   prech_width_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(ram_en_n) |-> (hi_run >= 16'(T_PC)));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      wr_done |=> !wr_done);

   // R6
   done_ready_chk: assert property (@(posedge clk) disable iff (rst)
      wr_done |-> wr_ready);

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      wr_ready |-> (ram_en_n && ram_we_n));
endmodule

bind sram_late_write_ctl sram_lw_chk #(
   .T_EL (T_EL),
   .T_PC (T_PC),
   .T_WP (T_WP),
   .T_WE (T_WE)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .ram_en_n (ram_en_n),
   .ram_we_n (ram_we_n),
   .wr_ready (wr_ready),
   .wr_done  (wr_done)
);

// File: tb/sram_late_write_ctl_tb_top.sv
module sram_late_write_ctl_tb_top;
   localparam int AW   = 8;
   localparam int T_AS = 2;
   localparam int T_AH = 1;
   localparam int T_EW = 1;
   localparam int T_DS = 4;
   localparam int T_DH = 2;
   localparam int T_WP = 3;
   localparam int T_WE = 2;
   localparam int T_EL = 4;
   localparam int T_PC = 3;
   // expected schedule from R3 and R5
   localparam int EXP_W = (T_EW > T_DS - T_AS) ? T_EW : T_DS - T_AS;
   localparam int WP_M  = (T_WP > T_WE) ? T_WP : T_WE;
   localparam int L_A   = (T_EL > T_AH) ? T_EL : T_AH;
   localparam int L_B   = (T_DH > WP_M) ? EXP_W + T_DH : EXP_W + WP_M;
   localparam int EXP_L = (L_A > L_B) ? L_A : L_B;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_req = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic          wr_bit = 1'b0;
   logic          wr_ready, wr_done, ram_en_n, ram_we_n, ram_din;
   logic [AW-1:0] ram_addr;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   sram_late_write_ctl #(
      .AW(AW), .T_AS(T_AS), .T_AH(T_AH), .T_EW(T_EW), .T_DS(T_DS),
      .T_DH(T_DH), .T_WP(T_WP), .T_WE(T_WE), .T_EL(T_EL), .T_PC(T_PC),
      .DROP_IDLE(1'b1)
   ) dut_i (
      .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_bit(wr_bit),
      .wr_ready(wr_ready), .wr_done(wr_done), .ram_en_n(ram_en_n),
      .ram_we_n(ram_we_n), .ram_addr(ram_addr), .ram_din(ram_din)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // pin-edge recorder, sampling away from the active edge
   int t_enf, t_enr, t_wef, t_wer, t_aset, t_adrop, t_dset, t_ddrop, t_done;
   int n_enf = 0;
   int n_done = 0;
   logic [AW-1:0] a_at_enf;
   logic d_at_wef, rdy_at_done;
   logic p_en = 1'b1, p_we = 1'b1, p_din = 1'b0;
   logic [AW-1:0] p_addr = '0;

   always @(negedge clk) begin
      if (ram_en_n != p_en) begin
         if (!ram_en_n) begin t_enf = cyc; a_at_enf = ram_addr; n_enf++; end
         else t_enr = cyc;
      end
      if (ram_we_n != p_we) begin
         if (!ram_we_n) begin t_wef = cyc; d_at_wef = ram_din; end
         else t_wer = cyc;
      end
      if (ram_addr != p_addr) begin
         if (ram_addr != '0) t_aset = cyc; else t_adrop = cyc;
      end
      if (ram_din != p_din) begin
         if (ram_din) t_dset = cyc; else t_ddrop = cyc;
      end
      if (wr_done) begin t_done = cyc; rdy_at_done = wr_ready; n_done++; end
      p_en = ram_en_n; p_we = ram_we_n; p_addr = ram_addr; p_din = ram_din;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [AW-1:0] a, input logic d);
      @(negedge clk);
      wr_req = 1'b1; wr_addr = a; wr_bit = d;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_req = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!wr_done);
      #1;
   endtask

   task automatic t_reset();
      int c0;
      repeat (3) @(negedge clk);
      chk("R1", "en_n in reset", int'(ram_en_n), 1);
      chk("R1", "we_n in reset", int'(ram_we_n), 1);
      rst = 1'b0;
      c0 = cyc;
      do @(negedge clk); while (!wr_ready);
      chk("R1", "edges to ready", cyc - c0, T_PC);
      repeat (4) @(negedge clk);
      chk("R1", "done after reset", n_done, 0);
   endtask

   task automatic t_single(input logic [AW-1:0] a);
      send(a, 1'b1);
      wait_done();
      chk("R2", "addr at enable fall", int'(a_at_enf), int'(a));
      chk("R2", "addr setup", t_enf - t_aset, T_AS);
      chk("R2", "addr hold", t_adrop - t_enf, T_AH);
      chk("R3", "we delay", t_wef - t_enf, EXP_W);
      chk("R4", "data at we fall", int'(d_at_wef), 1);
      chk("R4", "data setup", t_wef - t_dset, T_AS + EXP_W);
      chk("R4", "data hold", t_ddrop - t_wef, T_DH);
      chk("R5", "enable low width", t_enr - t_enf, EXP_L);
      chk("R5", "we rises with enable", t_wer, t_enr);
      chk("R6", "precharge to done", t_done - t_enr, T_PC);
      chk("R6", "ready with done", int'(rdy_at_done), 1);
      @(negedge clk);
      chk("R6", "done one cycle", int'(wr_done), 0);
   endtask

   task automatic t_zero_bit();
      send(8'h3C, 1'b0);
      wait_done();
      chk("R4", "zero data at we fall", int'(d_at_wef), 0);
      chk("R2", "addr at enable fall", int'(a_at_enf), 8'h3C);
   endtask

   task automatic t_busy_ignore();
      int e0;
      e0 = n_enf;
      send(8'hA5, 1'b1);
      while (ram_en_n) @(negedge clk);
      wr_req = 1'b1; wr_addr = 8'h5A;
      @(negedge clk);
      chk("R7", "ready low while busy", int'(wr_ready), 0);
      wr_req = 1'b0;
      wait_done();
      chk("R7", "addr unchanged", int'(a_at_enf), 8'hA5);
      repeat (T_PC + 6) @(negedge clk);
      chk("R7", "enable falls", n_enf - e0, 1);
      chk("R7", "strobes idle", int'(ram_en_n && ram_we_n && wr_ready), 1);
   endtask

   task automatic t_back_to_back();
      int r1;
      @(negedge clk);
      wr_req = 1'b1; wr_addr = 8'h11; wr_bit = 1'b1;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_addr = 8'h22;
      wait_done();
      r1 = t_enr;
      do @(negedge clk); while (wr_ready);
      wr_req = 1'b0;
      wait_done();
      chk("R8", "enable-high gap", t_enf - r1, T_PC + 1 + T_AS);
      chk("R8", "second addr", int'(a_at_enf), 8'h22);
   endtask

   initial begin
      t_reset();
      t_single(8'h81);
      t_single(8'h07);
      t_zero_bit();
      t_busy_ignore();
      t_back_to_back();
      repeat (5) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL all requirements watchdog: actual=%0d cycles expected<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule